// File: doc/BRIEF.md
# Idle-Timeout Power-Gating Controller

This controller sits beside one functional unit of a processor. It switches the unit's supply off by itself after the unit has sat idle for a programmable number of cycles, and switches it back on when the issue stage presents work. The issue stage drives a single request/busy strobe. The controller answers with a power enable for the unit's header switch and a ready flag that tells issue whether an operation may be sent this cycle.

While the unit is off, the controller separates two phases: the early part, in which the energy spent on switching has not yet been recovered, and the part after a fixed break-even time, in which gating has paid off. A wake-up taken in the early phase is counted as premature. A wake-up taken after break-even is counted as profitable. Software or a profiler can read the two counts to tune the idle threshold.

The idle threshold is an input that may change at any time. The break-even time and the wake-up latency are parameters fixed by the circuit technology.

Top module: `pgate_ctrl`

## Requirements
- R1: While reset is held and after reset, the controller is in the active state, with ready = 1 and pwr_en = 1, and both event counters read zero.
- R2: In the active state, the controller moves to the early-off state after idle_thr + 1 consecutive cycles without a request. With idle_thr = 0, one idle cycle is enough.
- R3: A request in the active state restarts the idle count. A full idle_thr + 1 idle cycles must then elapse again before gating.
- R4: In the early-off state with no request, the controller moves to the paid-off state after BREAKEVEN + 1 cycles.
- R5: A request in the early-off state moves the controller to wake-up and adds one to premature_cnt. This holds even in the last early-off cycle, where the request wins over the move to paid-off.
- R6: A request in the paid-off state moves the controller to wake-up and adds one to profitable_cnt.
- R7: The wake-up state lasts exactly WAKE_LAT cycles and then returns to active. Requests during wake-up change neither its length nor the counters.
- R8: ready is 1 only in the active state. pwr_en is 1 in the active and wake-up states and 0 in both off states.
- R9: A new idle_thr value applies at the next idle comparison. Lowering it below the idle cycles already counted gates the unit on the next idle cycle. A change during wake-up does not shorten the wake-up.
- R10: Each event counter stops at its all-ones value instead of wrapping.
- R11: The state output encodes active as 0, early-off as 1, paid-off as 2 and wake-up as 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Work request / busy strobe from the issue stage |
| idle_thr | input | THR_W | Idle threshold in cycles, may change at runtime |
| pwr_en | output | 1 | Supply enable for the gated unit |
| ready | output | 1 | The unit may accept an operation |
| state | output | 2 | Current controller state (R11 encoding) |
| premature_cnt | output | CNT_W | Wake-ups taken before break-even |
| profitable_cnt | output | CNT_W | Wake-ups taken after break-even |

## Verification
Two functions can land on the same clock edge: the early-off timer reaching break-even, and a request arriving. The bench provokes this by choosing an idle gap of exactly idle_thr + BREAKEVEN + 1 cycles, so the request meets the final early-off cycle. It then checks that the next state is wake-up and that only the premature count moved. A second coincidence, a threshold lowered below the count already reached, is provoked mid-idle. It is judged by the unit gating on the very next edge.

// File: rtl/pgate_pkg.sv
package pgate_pkg;

   typedef enum logic [1:0] {
      PG_ACTIVE    = 2'd0,
      PG_OFF_EARLY = 2'd1,
      PG_OFF_PAID  = 2'd2,
      PG_WAKING    = 2'd3
   } pg_state_e;

   function automatic int pg_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pg_evt_cnt.sv
module pg_evt_cnt #(
   parameter int CNT_W    = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt
);

   localparam logic [CNT_W-1:0] C_MAX = '1;
   localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);

   if (CNT_W < 1) begin : g_bad_width
      $error("pg_evt_cnt: CNT_W must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   if (SATURATE) begin : g_sat
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (inc && (cnt_q != C_MAX)) begin
            cnt_q <= cnt_q + C_ONE;
         end
      end
   end else begin : g_wrap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (inc) begin
            cnt_q <= cnt_q + C_ONE;
         end
      end
   end

   assign cnt = cnt_q;

endmodule

// File: rtl/pg_fsm.sv
module pg_fsm
   import pgate_pkg::*;
#(
   parameter int THR_W     = 8,
   parameter int BREAKEVEN = 24,
   parameter int WAKE_LAT  = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic [THR_W-1:0] idle_thr,
   output pg_state_e        state_o,
   output logic             ev_premature,
   output logic             ev_profitable
);

   localparam int BE_W  = $clog2(BREAKEVEN + 2);
   localparam int WK_W  = $clog2(WAKE_LAT + 1);
   localparam int TMR_W = pg_max(THR_W, pg_max(BE_W, WK_W));
   localparam logic [TMR_W-1:0] TMR_ONE = TMR_W'(1);
   localparam logic [TMR_W-1:0] BE_LAST = TMR_W'(BREAKEVEN);
   localparam logic [TMR_W-1:0] WK_LAST = TMR_W'(WAKE_LAT - 1);

   if (THR_W < 1) begin : g_bad_thr
      $error("pg_fsm: THR_W must be at least 1");
   end
   if (BREAKEVEN < 0) begin : g_bad_be
      $error("pg_fsm: BREAKEVEN must not be negative");
   end
   if (WAKE_LAT < 1) begin : g_bad_wake
      $error("pg_fsm: WAKE_LAT must be at least 1");
   end

   pg_state_e        st_q, st_d;
   logic [TMR_W-1:0] tmr_q, tmr_d;
   logic [TMR_W-1:0] thr_ext;
   logic             prem_d, prof_d;

   assign thr_ext = TMR_W'(idle_thr);

   // One shared timer: idle count, off time or wake time, by state.
   always_comb begin
      st_d   = st_q;
      tmr_d  = tmr_q;
      prem_d = 1'b0;
      prof_d = 1'b0;
      unique case (st_q)
         PG_ACTIVE: begin
            if (req) begin
               tmr_d = '0;
            end else if (tmr_q >= thr_ext) begin
               st_d  = PG_OFF_EARLY;
               tmr_d = '0;
            end else begin
               tmr_d = tmr_q + TMR_ONE;
            end
         end
         PG_OFF_EARLY: begin
            if (req) begin
               st_d   = PG_WAKING;
               tmr_d  = '0;
               prem_d = 1'b1;
            end else if (tmr_q == BE_LAST) begin
               st_d  = PG_OFF_PAID;
               tmr_d = '0;
            end else begin
               tmr_d = tmr_q + TMR_ONE;
            end
         end
         PG_OFF_PAID: begin
            if (req) begin
               st_d   = PG_WAKING;
               tmr_d  = '0;
               prof_d = 1'b1;
            end
         end
         PG_WAKING: begin
            if (tmr_q == WK_LAST) begin
               st_d  = PG_ACTIVE;
               tmr_d = '0;
            end else begin
               tmr_d = tmr_q + TMR_ONE;
            end
         end
         default: begin
            st_d  = PG_ACTIVE;
            tmr_d = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= PG_ACTIVE;
         tmr_q <= '0;
      end else begin
         st_q  <= st_d;
         tmr_q <= tmr_d;
      end
   end

   assign state_o       = st_q;
   assign ev_premature  = prem_d;
   assign ev_profitable = prof_d;

endmodule

// File: rtl/pgate_ctrl.sv
module pgate_ctrl
   import pgate_pkg::*;
#(
   parameter int THR_W     = 8,
   parameter int BREAKEVEN = 24,
   parameter int WAKE_LAT  = 20,
   parameter int CNT_W     = 16,
   parameter bit SATURATE  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic [THR_W-1:0] idle_thr,
   output logic             pwr_en,
   output logic             ready,
   output logic [1:0]       state,
   output logic [CNT_W-1:0] premature_cnt,
   output logic [CNT_W-1:0] profitable_cnt
);

   pg_state_e st;
   logic      ev_prem, ev_prof;

   pg_fsm #(
      .THR_W    (THR_W),
      .BREAKEVEN(BREAKEVEN),
      .WAKE_LAT (WAKE_LAT)
   ) i_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .req          (req),
      .idle_thr     (idle_thr),
      .state_o      (st),
      .ev_premature (ev_prem),
      .ev_profitable(ev_prof)
   );

   pg_evt_cnt #(
      .CNT_W   (CNT_W),
      .SATURATE(SATURATE)
   ) i_cnt_prem (
      .clk  (clk),
      .rst_n(rst_n),
      .inc  (ev_prem),
      .cnt  (premature_cnt)
   );

   pg_evt_cnt #(
      .CNT_W   (CNT_W),
      .SATURATE(SATURATE)
   ) i_cnt_prof (
      .clk  (clk),
      .rst_n(rst_n),
      .inc  (ev_prof),
      .cnt  (profitable_cnt)
   );

   assign pwr_en = (st == PG_ACTIVE) || (st == PG_WAKING);
   assign ready  = (st == PG_ACTIVE);
   assign state  = st;

endmodule

// File: rtl/pgate_ctrl_chk.sv
module pgate_ctrl_chk #(
   parameter int WAKE_LAT = 20,
   parameter int CNT_W    = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req,
   input logic [1:0]       state,
   input logic             pwr_en,
   input logic             ready,
   input logic [CNT_W-1:0] premature_cnt,
   input logic [CNT_W-1:0] profitable_cnt
);

   localparam int WL_W = $clog2(WAKE_LAT + 1) + 1;
   localparam logic [WL_W-1:0]  WL_LAT  = WL_W'(WAKE_LAT);
   localparam logic [WL_W-1:0]  WL_LAST = WL_W'(WAKE_LAT - 1);
   localparam logic [WL_W-1:0]  WL_ONE  = WL_W'(1);
   localparam logic [CNT_W-1:0] C_MAX   = '1;
   localparam logic [CNT_W-1:0] C_ONE   = CNT_W'(1);

   logic [WL_W-1:0] wk_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wk_len <= '0;
      end else if (state == 2'd3) begin
         wk_len <= wk_len + WL_ONE;
      end else begin
         wk_len <= '0;
      end
   end

   AST_GATED_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 2'd1 || state == 2'd2) |-> (!pwr_en && !ready)); // R8

   AST_ACTIVE_NO_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 2'd0) |=> (state == 2'd0 || state == 2'd1)); // R2

   AST_BUSY_HOLDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 2'd0 && req) |=> (state == 2'd0)); // R3

   AST_PAID_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 2'd2 && !req) |=> (state == 2'd2)); // R4

   AST_EARLY_REQ_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 2'd1 && req && premature_cnt != C_MAX) |=>
         (state == 2'd3 && premature_cnt == $past(premature_cnt) + C_ONE)); // R5

   AST_PAID_REQ_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 2'd2 && req && profitable_cnt != C_MAX) |=>
         (state == 2'd3 && profitable_cnt == $past(profitable_cnt) + C_ONE)); // R6

   AST_WAKE_NO_OVERSTAY: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 2'd3) |-> (wk_len < WL_LAT)); // R7

   AST_WAKE_NO_EARLY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 2'd3 && wk_len < WL_LAST) |=> (state == 2'd3)); // R7

   AST_WAKE_COUNTS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 2'd3) |=> ($stable(premature_cnt) && $stable(profitable_cnt))); // R7

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (premature_cnt == C_MAX) |=> (premature_cnt == C_MAX)); // R10

endmodule

bind pgate_ctrl pgate_ctrl_chk #(
   .WAKE_LAT(WAKE_LAT),
   .CNT_W   (CNT_W)
) i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req           (req),
   .state         (state),
   .pwr_en        (pwr_en),
   .ready         (ready),
   .premature_cnt (premature_cnt),
   .profitable_cnt(profitable_cnt)
);

// File: tb/test_pgate_ctrl.sv
module test_pgate_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int THR_W      = 8;
   localparam int BE         = 6;
   localparam int WL         = 10;
   localparam int CNT_W      = 4;
   localparam int CMAX       = (1 << CNT_W) - 1;
   localparam int NVEC       = 10;

   // {threshold, idle gap, expected state before the request}
   localparam logic [23:0] VEC [NVEC] = '{
      {8'd16, 8'd5,  8'd0},
      {8'd16, 8'd16, 8'd0},
      {8'd16, 8'd17, 8'd1},
      {8'd16, 8'd23, 8'd1},
      {8'd16, 8'd24, 8'd2},
      {8'd0,  8'd1,  8'd1},
      {8'd0,  8'd8,  8'd2},
      {8'd48, 8'd49, 8'd1},
      {8'd48, 8'd60, 8'd2},
      {8'd3,  8'd3,  8'd0}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req = 1'b0;
   logic [THR_W-1:0] idle_thr = '0;
   logic             pwr_en, ready;
   logic [1:0]       state;
   logic [CNT_W-1:0] premature_cnt, profitable_cnt;

   int  n_checks = 0;
   int  n_errors = 0;
   int  e_prem = 0;
   int  e_prof = 0;
   bit  done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   pgate_ctrl #(
      .THR_W    (THR_W),
      .BREAKEVEN(BE),
      .WAKE_LAT (WL),
      .CNT_W    (CNT_W),
      .SATURATE (1'b1)
   ) i_pgate_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .req           (req),
      .idle_thr      (idle_thr),
      .pwr_en        (pwr_en),
      .ready         (ready),
      .state         (state),
      .premature_cnt (premature_cnt),
      .profitable_cnt(profitable_cnt)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   function automatic int sat_inc(input int v);
      return (v >= CMAX) ? CMAX : v + 1;
   endfunction

   task automatic check_outputs(input string tag, input int exp_state);
      check({tag, " R11 state"}, int'(state), exp_state);
      check({tag, " R8 ready"}, int'(ready), (exp_state == 0) ? 1 : 0);
      check({tag, " R8 pwr_en"}, int'(pwr_en), (exp_state == 0 || exp_state == 3) ? 1 : 0);
   endtask

   task automatic check_counts(input string tag);
      check({tag, " R5 premature_cnt"}, int'(premature_cnt), e_prem);
      check({tag, " R6 profitable_cnt"}, int'(profitable_cnt), e_prof);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: state while reset is held
      check_outputs("R1 in reset", 0);
      check_counts("R1 in reset");
      req = 1'b1;
      rst_n = 1'b1;
      tick(1);
      check_outputs("R1 after reset", 0);
      check_counts("R1 after reset");

      // Table walk: R2, R4, R5, R6, R7 (gap 23 is the R5 break-even coincidence)
      for (int v = 0; v < NVEC; v++) begin
         int thr, gap, est;
         thr = int'(VEC[v][23:16]);
         gap = int'(VEC[v][15:8]);
         est = int'(VEC[v][7:0]);
         req = 1'b1;
         tick(1);
         idle_thr = THR_W'(thr);
         req = 1'b0;
         tick(gap);
         check_outputs($sformatf("R2 R4 vec%0d idle", v), est);
         req = 1'b1;
         tick(1);
         if (est == 1) e_prem = sat_inc(e_prem);
         if (est == 2) e_prof = sat_inc(e_prof);
         check_outputs($sformatf("R5 R6 vec%0d req", v), (est == 0) ? 0 : 3);
         check_counts($sformatf("vec%0d", v));
         tick(WL - 1);
         if (est != 0) check_outputs($sformatf("R7 vec%0d wake end-1", v), 3);
         tick(1);
         check_outputs($sformatf("R7 vec%0d wake done", v), 0);
      end

      // R3: a busy cycle restarts the idle count
      idle_thr = 8'd10;
      req = 1'b0;
      tick(8);
      req = 1'b1;
      tick(1);
      req = 1'b0;
      tick(10);
      check_outputs("R3 restarted count", 0);
      tick(1);
      check_outputs("R3 gated after restart", 1);
      req = 1'b1;
      tick(1);
      e_prem = sat_inc(e_prem);
      tick(WL);
      check_outputs("R3 recovered", 0);

      // R9: lowering the threshold below the elapsed count gates next edge
      idle_thr = 8'd40;
      req = 1'b0;
      tick(20);
      check_outputs("R9 before lower", 0);
      idle_thr = 8'd10;
      tick(1);
      check_outputs("R9 after lower", 1);
      req = 1'b1;
      tick(1);
      e_prem = sat_inc(e_prem);
      check_outputs("R9 wake entered", 3);

      // R7 R9: threshold change and requests during wake are ignored
      req = 1'b0;
      idle_thr = 8'd0;
      tick(2);
      req = 1'b1;
      tick(3);
      req = 1'b0;
      check_outputs("R7 wake with req", 3);
      check_counts("R7 wake with req");
      tick(WL - 6);
      check_outputs("R9 wake not shortened", 3);
      tick(1);
      check_outputs("R7 wake exact length", 0);
      tick(1);
      check_outputs("R2 zero threshold", 1);
      req = 1'b1;
      tick(1);
      e_prem = sat_inc(e_prem);
      tick(WL);
      check_counts("R2 zero threshold");

      // R10: premature counter saturates
      for (int k = 0; k < 14; k++) begin
         idle_thr = 8'd0;
         req = 1'b0;
         tick(1);
         req = 1'b1;
         tick(1);
         e_prem = sat_inc(e_prem);
         tick(WL);
      end
      check("R10 premature saturated", int'(premature_cnt), CMAX);
      check_counts("R10 final");
      check_outputs("R10 final", 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule